// File: doc/BRIEF.md
# Converter Power-Up and Calibration Sequencer

This controller runs on the sample clock of a pipelined, self-calibrating analog-to-digital converter. It drives the converter's reset line, its calibrate line and its active-low power-down line. It also tells downstream capture logic when converted samples can be trusted. A power-enable request starts the full bring-up. The converter leaves power-down, the sequencer waits for the references to settle, then it issues a reset pulse, then a calibrate pulse. It holds off for the calibration period and finally lets the pipeline flush before it declares the data path ready.

When the converter is up, a software recalibration request or a temperature-drift trigger runs a shorter reset-and-calibrate pass. The converter stays powered during that pass, so the settling wait is skipped. A request that arrives while a sequence is running is remembered and served when that sequence ends. Dropping power-enable parks the converter in power-down at once. Every return from power-down runs the whole bring-up again.

The settling wait is derived from a clock-frequency parameter and a settling time in microseconds. The pulse widths, the calibration length (272,800 clocks by default) and the 13-clock flush are parameters.

Top module: `adc_cal_sequencer`

## Requirements
- R1: While `rst` is high and on the cycle after it is released with `pwrEn` low, `adcPdN`, `adcReset`, `adcCal`, `busy` and `ready` are all 0 and `discard` is 1.
- R2: One clock edge after `pwrEn` is seen high in the off state, `adcPdN` goes to 1. For the next SETTLE cycles (CLK_HZ·SETTLE_US/10^6, at least 1), `adcReset` and `adcCal` stay 0. `adcReset` rises on the cycle after that wait.
- R3: `adcReset` is high for exactly RST_WIDTH consecutive cycles, and RST_WIDTH must be at least 2.
- R4: `adcCal` rises on the cycle right after `adcReset` falls and stays high for exactly CAL_WIDTH cycles, with CAL_WIDTH at least 2. `adcCal` never rises unless `adcReset` was high in the previous cycle.
- R5: When `adcCal` falls, CAL_CYCLES calibration cycles follow, then FLUSH_CYCLES (default 13) flush cycles. `ready` rises after that span, so it comes CAL_CYCLES+FLUSH_CYCLES cycles after the first cycle with `adcCal` low.
- R6: `ready` is 1 only after a completed sequence. `discard` is the inverse of `ready`. `busy` is 1 exactly when `adcPdN` is 1 and `ready` is 0.
- R7: A one-cycle `recalReq` or `driftTrig` seen while `ready` is 1 makes `adcReset` rise on the next cycle, with no settling wait.
- R8: Requests seen while a sequence is running are held and produce exactly one extra reset-and-calibrate pass. That pass starts right after the flush, with no `ready` cycle in between.
- R9: With `pwrEn` low, `adcPdN` is 0 from the next cycle on, and `adcReset`, `adcCal`, `busy` and `ready` are 0. This holds in every state. When `pwrEn` returns, the full sequence of R2 to R5 runs again.
- R10: `recalReq` and `driftTrig` have no effect while the converter is powered down. They neither start a calibration nor leave a request pending for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter sample clock |
| rst | input | 1 | Synchronous system reset, active high |
| pwrEn | input | 1 | Request to keep the converter powered |
| recalReq | input | 1 | Recalibration request strobe |
| driftTrig | input | 1 | Temperature-drift recalibration strobe |
| adcReset | output | 1 | Converter reset line, active high |
| adcCal | output | 1 | Converter calibrate line, active high |
| adcPdN | output | 1 | Converter power-down line, active low |
| busy | output | 1 | Sequence in progress while powered |
| ready | output | 1 | Samples are valid |
| discard | output | 1 | Samples must be dropped |

## Verification
The hardest case to reach is a request that lands while a calibration is already running, combined with power being removed partway through. The converter must then drop every pending request, and it must settle again on power return. The stimulus watches the pins: it waits for the calibrate line to fall, then injects requests of both kinds in the calibration-wait window. It removes `pwrEn` in a later pass, again in that window, and probes with strobes while the converter is off. Pulse widths, the settle length and the calibrate-to-ready span are measured from the pins on every pass.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_OFF,
    SEQ_SETTLE,
    SEQ_RESET,
    SEQ_CALPULSE,
    SEQ_CALWAIT,
    SEQ_FLUSH,
    SEQ_READY
  } seqState_e;

  typedef enum logic [2:0] {
    LEN_SETTLE,
    LEN_RESET,
    LEN_CALPULSE,
    LEN_CALWAIT,
    LEN_FLUSH
  } lenSel_e;

  // strobes from control to the timer/request datapath
  typedef struct packed {
    logic    load;
    lenSel_e lenSel;
    logic    clrPend;
    logic    armReq;
  } seqStrobe_t;

endpackage

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 250000,
  parameter int RST_WIDTH     = 4,
  parameter int CAL_WIDTH     = 4,
  parameter int CAL_CYCLES    = 272800,
  parameter int FLUSH_CYCLES  = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strobe,
  input  logic       reqIn,
  output logic       expired,
  output logic       pending
);

  localparam int MAX_A   = (SETTLE_CYCLES > CAL_CYCLES) ? SETTLE_CYCLES : CAL_CYCLES;
  localparam int MAX_B   = (RST_WIDTH > CAL_WIDTH) ? RST_WIDTH : CAL_WIDTH;
  localparam int MAX_C   = (MAX_B > FLUSH_CYCLES) ? MAX_B : FLUSH_CYCLES;
  localparam int MAX_LEN = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (strobe.lenSel)
      LEN_SETTLE:   loadVal = CNT_W'(SETTLE_CYCLES - 1);
      LEN_RESET:    loadVal = CNT_W'(RST_WIDTH - 1);
      LEN_CALPULSE: loadVal = CNT_W'(CAL_WIDTH - 1);
      LEN_CALWAIT:  loadVal = CNT_W'(CAL_CYCLES - 1);
      default:      loadVal = CNT_W'(FLUSH_CYCLES - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (strobe.load) begin
      count <= loadVal;
    end else if (count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign expired = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
    end else if (strobe.clrPend) begin
      pending <= 1'b0;
    end else if (strobe.armReq && reqIn) begin
      pending <= 1'b1;
    end
  end

  // a held request survives until control consumes or discards it
  assert_pend_kept_R8: assert property (@(posedge clk) disable iff (rst)
    pending && !strobe.clrPend |=> pending);

  // a request while armed is captured
  assert_pend_capture_R8: assert property (@(posedge clk) disable iff (rst)
    strobe.armReq && reqIn && !strobe.clrPend |=> pending);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwrEn,
  input  logic       reqIn,
  input  logic       expired,
  input  logic       pending,
  output seqStrobe_t strobe,
  output logic       adcReset,
  output logic       adcCal,
  output logic       adcPdN,
  output logic       busy,
  output logic       ready,
  output logic       discard
);

  seqState_e state, nextState;

  always_comb begin
    nextState      = state;
    strobe.load    = 1'b0;
    strobe.lenSel  = LEN_SETTLE;
    strobe.clrPend = 1'b0;
    strobe.armReq  = (state != SEQ_OFF);
    if (!pwrEn) begin
      nextState      = SEQ_OFF;
      strobe.clrPend = 1'b1;
      strobe.armReq  = 1'b0;
    end else begin
      unique case (state)
        SEQ_OFF: begin
          nextState      = SEQ_SETTLE;
          strobe.load    = 1'b1;
          strobe.lenSel  = LEN_SETTLE;
          strobe.clrPend = 1'b1;
        end
        SEQ_SETTLE: if (expired) begin
          nextState     = SEQ_RESET;
          strobe.load   = 1'b1;
          strobe.lenSel = LEN_RESET;
        end
        SEQ_RESET: if (expired) begin
          nextState     = SEQ_CALPULSE;
          strobe.load   = 1'b1;
          strobe.lenSel = LEN_CALPULSE;
        end
        SEQ_CALPULSE: if (expired) begin
          nextState     = SEQ_CALWAIT;
          strobe.load   = 1'b1;
          strobe.lenSel = LEN_CALWAIT;
        end
        SEQ_CALWAIT: if (expired) begin
          nextState     = SEQ_FLUSH;
          strobe.load   = 1'b1;
          strobe.lenSel = LEN_FLUSH;
        end
        SEQ_FLUSH: if (expired) begin
          if (pending || reqIn) begin
            nextState      = SEQ_RESET;
            strobe.load    = 1'b1;
            strobe.lenSel  = LEN_RESET;
            strobe.clrPend = 1'b1;
          end else begin
            nextState = SEQ_READY;
          end
        end
        SEQ_READY: begin
          strobe.clrPend = 1'b1;
          if (reqIn) begin
            nextState     = SEQ_RESET;
            strobe.load   = 1'b1;
            strobe.lenSel = LEN_RESET;
          end
        end
        default: nextState = SEQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SEQ_OFF;
    else     state <= nextState;
  end

  // pins decode a register only, so they move on the rising edge alone
  assign adcPdN   = (state != SEQ_OFF);
  assign adcReset = (state == SEQ_RESET);
  assign adcCal   = (state == SEQ_CALPULSE);
  assign ready    = (state == SEQ_READY);
  assign busy     = adcPdN && !ready;
  assign discard  = !ready;

  assert_pins_parked_R9: assert property (@(posedge clk) disable iff (rst)
    !adcPdN |-> !adcReset && !adcCal && !ready && !busy);

  assert_off_follows_R9: assert property (@(posedge clk) disable iff (rst)
    !pwrEn |=> !adcPdN);

  assert_settle_first_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(adcPdN) |-> !adcReset && !adcCal);

  assert_rst_min_width_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(adcReset) && adcPdN |-> $past(adcReset, 2));

  assert_cal_after_reset_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(adcCal) |-> $past(adcReset));

  assert_cal_min_width_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(adcCal) && adcPdN |-> $past(adcCal, 2));

  assert_discard_after_cal_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(adcCal) |=> discard);

  assert_ready_clean_R6: assert property (@(posedge clk) disable iff (rst)
    ready |-> !discard && !busy && !adcCal && !adcReset && adcPdN);

  assert_one_state_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({adcReset, adcCal, ready}));

endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CLK_HZ       = 2500000,
  parameter int SETTLE_US    = 100000,
  parameter int RST_WIDTH    = 4,
  parameter int CAL_WIDTH    = 4,
  parameter int CAL_CYCLES   = 272800,
  parameter int FLUSH_CYCLES = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic pwrEn,
  input  logic recalReq,
  input  logic driftTrig,
  output logic adcReset,
  output logic adcCal,
  output logic adcPdN,
  output logic busy,
  output logic ready,
  output logic discard
);

  localparam longint SETTLE_RAW    = (longint'(CLK_HZ) * longint'(SETTLE_US)) / 64'd1000000;
  localparam int     SETTLE_CYCLES = (SETTLE_RAW < 1) ? 1 : int'(SETTLE_RAW);

  seqStrobe_t strobe;
  logic       expired;
  logic       pending;
  logic       reqIn;

  assign reqIn = recalReq || driftTrig;

  adc_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .pwrEn    (pwrEn),
    .reqIn    (reqIn),
    .expired  (expired),
    .pending  (pending),
    .strobe   (strobe),
    .adcReset (adcReset),
    .adcCal   (adcCal),
    .adcPdN   (adcPdN),
    .busy     (busy),
    .ready    (ready),
    .discard  (discard)
  );

  adc_seq_datapath #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .RST_WIDTH     (RST_WIDTH),
    .CAL_WIDTH     (CAL_WIDTH),
    .CAL_CYCLES    (CAL_CYCLES),
    .FLUSH_CYCLES  (FLUSH_CYCLES)
  ) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .reqIn   (reqIn),
    .expired (expired),
    .pending (pending)
  );

endmodule

// File: tb/adc_cal_sequencer_bench.sv
module adc_cal_sequencer_bench;

  localparam int CLK_HZ = 1000000;
  localparam int SET_US = 20;
  localparam int S      = 20;   // 1 MHz * 20 us
  localparam int RW     = 4;
  localparam int CW     = 3;
  localparam int CC     = 40;
  localparam int FL     = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwrEn = 1'b0, recalReq = 1'b0, driftTrig = 1'b0;
  logic adcReset, adcCal, adcPdN, busy, ready, discard;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_cal_sequencer #(
    .CLK_HZ(CLK_HZ), .SETTLE_US(SET_US), .RST_WIDTH(RW),
    .CAL_WIDTH(CW), .CAL_CYCLES(CC), .FLUSH_CYCLES(FL)
  ) u_adc_cal_sequencer (
    .clk(clk), .rst(rst), .pwrEn(pwrEn), .recalReq(recalReq), .driftTrig(driftTrig),
    .adcReset(adcReset), .adcCal(adcCal), .adcPdN(adcPdN),
    .busy(busy), .ready(ready), .discard(discard)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase names and remaining cycle count
  typedef enum int {P_OFF, P_SET, P_RST, P_CALP, P_CALW, P_FL, P_RDY} phase_e;
  phase_e mPhase = P_OFF;
  int     mRem = 0;
  bit     mPend = 0;

  always @(posedge clk) begin
    bit req;
    req = recalReq | driftTrig;
    if (rst) begin
      mPhase = P_OFF; mPend = 0;
    end else if (!pwrEn) begin
      mPhase = P_OFF; mPend = 0;
    end else begin
      case (mPhase)
        P_OFF:  begin mPhase = P_SET; mRem = S; end
        P_SET:  begin mPend |= req; mRem--; if (mRem == 0) begin mPhase = P_RST; mRem = RW; end end
        P_RST:  begin mPend |= req; mRem--; if (mRem == 0) begin mPhase = P_CALP; mRem = CW; end end
        P_CALP: begin mPend |= req; mRem--; if (mRem == 0) begin mPhase = P_CALW; mRem = CC; end end
        P_CALW: begin mPend |= req; mRem--; if (mRem == 0) begin mPhase = P_FL; mRem = FL; end end
        P_FL: begin
          mRem--;
          if (mRem == 0) begin
            if (mPend || req) begin mPend = 0; mPhase = P_RST; mRem = RW; end
            else mPhase = P_RDY;
          end else mPend |= req;
        end
        default: if (req) begin mPhase = P_RST; mRem = RW; end
      endcase
    end
  end

  // pin measurements
  logic prevPdN = 0, prevRst = 0, prevCal = 0;
  int settleCnt = 0, lastSettle = -1, rstLen = 0, calLen = 0;
  int c2rCnt = 0, calCount = 0;
  bit inSettle = 0, inC2r = 0;

  always @(negedge clk) begin
    if (!rst) begin
      // per-cycle comparison with the reference
      check(adcPdN === (mPhase != P_OFF), "R9 pdN", adcPdN, mPhase != P_OFF);
      check(adcReset === (mPhase == P_RST), "R3 reset", adcReset, mPhase == P_RST);
      check(adcCal === (mPhase == P_CALP), "R4 cal", adcCal, mPhase == P_CALP);
      check(ready === (mPhase == P_RDY), "R6 ready", ready, mPhase == P_RDY);
      check(busy === (mPhase != P_OFF && mPhase != P_RDY), "R6 busy", busy,
            mPhase != P_OFF && mPhase != P_RDY);
      check(discard === (mPhase != P_RDY), "R6 discard", discard, mPhase != P_RDY);

      if (adcPdN && !prevPdN) begin inSettle = 1; settleCnt = 1; end
      else if (inSettle) begin
        if (adcReset) begin lastSettle = settleCnt; inSettle = 0;
          check(settleCnt == S, "R2 settle length", settleCnt, S);
        end else settleCnt++;
      end
      if (adcReset) rstLen++;
      else if (prevRst) begin
        if (adcPdN) check(rstLen == RW, "R3 reset width", rstLen, RW);
        rstLen = 0;
      end
      if (adcCal && !prevCal) calCount++;
      if (adcCal) calLen++;
      else if (prevCal) begin
        if (adcPdN) check(calLen == CW, "R4 cal width", calLen, CW);
        check(prevRst == 0 && !adcReset, "R4 cal/reset overlap", adcReset, 0);
        calLen = 0; inC2r = 1; c2rCnt = 1;
      end else if (inC2r) begin
        if (!adcPdN || adcCal) inC2r = 0;
        else if (ready) begin
          check(c2rCnt == CC + FL, "R5 cal to ready", c2rCnt, CC + FL);
          inC2r = 0;
        end else c2rCnt++;
      end
      if (!adcPdN) inSettle = 0;
    end
    prevPdN = adcPdN; prevRst = adcReset; prevCal = adcCal;
  end

  task automatic waitReady();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  task automatic waitCalFall();
    @(negedge clk);
    while (!adcCal) @(negedge clk);
    while (adcCal) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check(!adcPdN && !adcReset && !adcCal && !busy && !ready && discard, "R1 reset state",
          {adcPdN, adcReset, adcCal, busy, ready, discard}, 6'b000001);
    rst = 1'b0;
    @(negedge clk);
    check(!adcPdN && !busy && discard, "R1 after release", adcPdN, 0);

    // bring-up
    pwrEn = 1'b1;
    waitReady();
    check(calCount == 1, "R5 single calibration", calCount, 1);
    check(lastSettle == S, "R2 measured settle", lastSettle, S);

    // request while ready: immediate reset
    recalReq = 1'b1; @(negedge clk); recalReq = 1'b0;
    check(adcReset == 1'b1, "R7 immediate reset", adcReset, 1);
    waitReady();
    check(calCount == 2, "R7 recal done", calCount, 2);

    // drift trigger, then requests while busy collapse to one extra pass
    base = calCount;
    driftTrig = 1'b1; @(negedge clk); driftTrig = 1'b0;
    check(adcReset == 1'b1, "R7 drift reset", adcReset, 1);
    waitCalFall();
    recalReq = 1'b1; @(negedge clk); recalReq = 1'b0;
    repeat (5) @(negedge clk);
    driftTrig = 1'b1; @(negedge clk); driftTrig = 1'b0;
    waitReady();
    check(calCount == base + 2, "R8 one held pass", calCount, base + 2);

    // power removal mid-calibration, strobes while off
    recalReq = 1'b1; @(negedge clk); recalReq = 1'b0;
    waitCalFall();
    recalReq = 1'b1; @(negedge clk); recalReq = 1'b0;
    repeat (4) @(negedge clk);
    pwrEn = 1'b0;
    @(negedge clk);
    check(!adcPdN && !busy && !ready, "R9 power down", adcPdN, 0);
    base = calCount;
    recalReq = 1'b1; driftTrig = 1'b1; @(negedge clk);
    recalReq = 1'b0; driftTrig = 1'b0;
    repeat (10) @(negedge clk);
    check(calCount == base && !adcReset && !adcPdN, "R10 ignored while off", calCount, base);
    pwrEn = 1'b1;
    waitReady();
    check(calCount == base + 1, "R10 no stale request", calCount, base + 1);
    check(lastSettle == S, "R9 settle after power return", lastSettle, S);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule